// File: doc/BRIEF.md
# Three-Counter Watchdog Timer

This block is a low-frequency watchdog and interval timer. It holds three counters that advance on a counter tick: two narrow counters with match values and one wide counter. `tick_i` is a one-cycle enable in the `clk_i` domain. Each narrow counter raises an event when it reaches its match value. It then either clears or keeps running up to its maximum value and wraps. The wide counter raises an event whenever a chosen bit of its count changes value. The counters can be chained, so that the first narrow counter feeds the second and the second feeds the wide one. This gives long intervals from a slow tick.

Each event triggers a programmable action: nothing, an interrupt, a reset request, or an interrupt followed by a reset request if that interrupt is still pending when the next event arrives. Software services a narrow counter by writing a clear strobe. If it does so while the count is still below a programmed lower limit, a separate action fires, which turns the block into a window watchdog. Register access uses a simple single-cycle write port and a combinational read port. Writes to configuration, match, lower-limit and count registers are ignored unless the block has been unlocked with a key.

Top module: `tri_wdog`

## Requirements
- R1: After reset every register reads zero, `irq_o` is 0 and `rst_req_o` is 0.
- R2: The config (word 1), match (word 2), lower-limit (word 3), narrow-count (word 4) and wide-count (word 5) registers accept writes only while unlocked. Writing `UNLOCK_KEY` to word 9 unlocks; writing any other value locks again. Word 9 reads back 1 when unlocked.
- R3: A change of an enable bit (control word 0, bits [2:0], one per counter) reaches its counter after two ticks. The first increment after an enable happens on the third tick.
- R4: With clear-on-match set (config bit 2 for counter 0, bit 10 for counter 1), a counter that sits at its match value (match word: counter 0 in [15:0], counter 1 in [31:16]) goes to 0 on the next advance, and its event fires on that advance.
- R5: With clear-on-match off, a counter passes its match value (the event still fires) and wraps to 0 only after its maximum value.
- R6: With config bit 3 set, counter 1 advances on the tick after the tick on which counter 0 cleared or wrapped, not on the same tick. The narrow counts read from word 4, with counter 0 in [15:0].
- R7: With config bit 11 set, the wide counter (word 5) advances on the tick after the tick on which counter 1 cleared or wrapped.
- R8: The wide counter fires its event on an advance that changes the count bit selected by config [28:24].
- R9: Action fields are config [1:0], [9:8] and [17:16] for counters 0, 1 and 2. Encoding: 0 none, 1 set interrupt status, 2 request reset, 3 set status or, if that status bit is already set, request reset. `rst_req_o` stays high until reset.
- R10: Writing 1 to control bit 4+i clears counter i. For a narrow counter whose count is then below its lower limit (lower word: counter 0 in [15:0], counter 1 in [31:16]), the lower-limit action (config [5:4] and [13:12], same encoding) fires.
- R11: Status (word 6) bit i is cleared by writing 1 to it. Writing 1 to bit i of word 7 sets it. Word 8 is the mask, and `irq_o` equals status AND mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Counter tick enable |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Register word address for reads and writes |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Read data for `addr_i` |
| irq_o | output | 3 | Masked interrupt, one bit per counter |
| rst_req_o | output | 1 | Sticky reset request |

## Verification
A counter that advances from a wrong internal value shows up in the count readback after the very next tick. A lost or early cascade carry shifts the upper count by one tick, which a read right after the lower counter clears exposes. A wrong enable pipeline moves the first increment away from the third tick. Faulty action resolution shows up in the same cycle as a wrong status bit or `irq_o`, or as a `rst_req_o` that rises on the first of two pending events instead of the second.

// File: rtl/twd_pkg.sv
package twd_pkg;

   typedef enum logic [1:0] {
      ACT_NONE    = 2'd0,
      ACT_IRQ     = 2'd1,
      ACT_RST     = 2'd2,
      ACT_IRQ_RST = 2'd3
   } act_e;

   // Configuration word, msb first
   typedef struct packed {
      logic [2:0] rsv31;
      logic [4:0] tog_bit;    // [28:24]
      logic [5:0] rsv23;
      act_e       mode2;      // [17:16]
      logic [1:0] rsv15;
      act_e       lmode1;     // [13:12]
      logic       casc12;     // [11]
      logic       clr1;       // [10]
      act_e       mode1;      // [9:8]
      logic [1:0] rsv7;
      act_e       lmode0;     // [5:4]
      logic       casc01;     // [3]
      logic       clr0;       // [2]
      act_e       mode0;      // [1:0]
   } cfg_t;

   localparam logic [31:0] CFG_WMASK   = 32'h1F03_3F3F;
   localparam int unsigned CTL_SVC_LSB = 4;

   localparam int unsigned A_CTL   = 0;
   localparam int unsigned A_CFG   = 1;
   localparam int unsigned A_MATCH = 2;
   localparam int unsigned A_LOWER = 3;
   localparam int unsigned A_CNTLO = 4;
   localparam int unsigned A_CNTHI = 5;
   localparam int unsigned A_STAT  = 6;
   localparam int unsigned A_SET   = 7;
   localparam int unsigned A_MASK  = 8;
   localparam int unsigned A_LOCK  = 9;

   typedef struct packed {
      logic set_irq;
      logic req_rst;
   } act_res_t;

   function automatic act_res_t resolve(input act_e mode, input logic fire, input logic pending);
      act_res_t r;
      r = '0;
      if (fire) begin
         case (mode)
            ACT_IRQ:     r.set_irq = 1'b1;
            ACT_RST:     r.req_rst = 1'b1;
            ACT_IRQ_RST: begin
               if (pending) r.req_rst = 1'b1;
               else         r.set_irq = 1'b1;
            end
            default: ;
         endcase
      end
      return r;
   endfunction

endpackage

// File: rtl/twd_counter.sv
module twd_counter #(
   parameter int unsigned CW = 16
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          tick_i,
   input  logic          adv_i,
   input  logic          load_i,
   input  logic [CW-1:0] load_val_i,
   input  logic          svc_i,
   input  logic [CW-1:0] match_i,
   input  logic          clr_on_match_i,
   output logic [CW-1:0] cnt_o,
   output logic          evt_o,
   output logic          carry_o
);

   if (CW < 2) begin : g_bad_width
      $error("twd_counter: CW must be at least 2");
   end

   logic          at_match;
   logic [CW-1:0] nxt;

   always_comb begin
      at_match = (cnt_o == match_i);
      nxt      = (clr_on_match_i && at_match) ? '0 : cnt_o + CW'(1);
   end

   assign evt_o = adv_i && at_match && !load_i && !svc_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_o   <= '0;
         carry_o <= 1'b0;
      end else if (load_i) begin
         cnt_o   <= load_val_i;
         carry_o <= 1'b0;
      end else if (svc_i) begin
         cnt_o   <= '0;
         carry_o <= 1'b0;
      end else if (tick_i) begin
         carry_o <= adv_i && (nxt == '0);
         if (adv_i) cnt_o <= nxt;
      end
   end

   // R4: a cleared-on-match counter returns to zero
   a_r4_clear_on_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (adv_i && !load_i && !svc_i && clr_on_match_i && cnt_o == match_i) |=> (cnt_o == '0));

endmodule

// File: rtl/twd_toggle.sv
module twd_toggle #(
   parameter int unsigned W  = 32,
   parameter int unsigned SW = $clog2(W)
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          adv_i,
   input  logic          load_i,
   input  logic [W-1:0]  load_val_i,
   input  logic          svc_i,
   input  logic [SW-1:0] sel_i,
   output logic [W-1:0]  cnt_o,
   output logic          evt_o
);

   if (W < 2 || (1 << SW) < W) begin : g_bad_width
      $error("twd_toggle: select width cannot address every bit");
   end

   logic [W-1:0] nxt;
   assign nxt   = cnt_o + W'(1);
   assign evt_o = adv_i && !load_i && !svc_i && (cnt_o[sel_i] != nxt[sel_i]);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     cnt_o <= '0;
      else if (load_i) cnt_o <= load_val_i;
      else if (svc_i)  cnt_o <= '0;
      else if (adv_i)  cnt_o <= nxt;
   end

   // R8: an event means the selected bit really changed
   a_r8_evt_bit_changed: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt_o |=> (cnt_o[$past(sel_i)] != $past(cnt_o[sel_i])));

endmodule

// File: rtl/tri_wdog.sv
module tri_wdog
   import twd_pkg::*;
#(
   parameter int unsigned DW         = 32,
   parameter int unsigned CW         = 16,
   parameter int unsigned C2W        = 32,
   parameter int unsigned ADDR_W     = 4,
   parameter logic [31:0] UNLOCK_KEY = 32'h5EC0_0D1E
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              tick_i,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DW-1:0]     wdata_i,
   output logic [DW-1:0]     rdata_o,
   output logic [2:0]        irq_o,
   output logic              rst_req_o
);

   localparam int unsigned NLO  = 2;
   localparam int unsigned NCTR = 3;
   localparam int unsigned SW   = $clog2(C2W);

   if (NLO * CW != DW) begin : g_bad_pack
      $error("tri_wdog: two narrow counters must fill one data word");
   end
   if (C2W > DW || SW > 5) begin : g_bad_wide
      $error("tri_wdog: wide counter exceeds data word or bit select");
   end
   if (DW != 32) begin : g_bad_dw
      $error("tri_wdog: config layout assumes a 32-bit data word");
   end
   if ((1 << ADDR_W) <= A_LOCK) begin : g_bad_addr
      $error("tri_wdog: address too narrow for register map");
   end

   function automatic logic hit(input logic [ADDR_W-1:0] a, input int unsigned r);
      return a == ADDR_W'(r);
   endfunction

   // ---------------- register state ----------------
   logic            unlocked_q;
   cfg_t            cfg_q;
   logic [DW-1:0]   match_q, lower_q;
   logic [NCTR-1:0] en_q, en_s1, en_s2, status_q, mask_q;
   logic            rst_req_q;

   logic wr_ctl, wr_cfg, wr_match, wr_lower, wr_cntlo, wr_cnthi, wr_stat, wr_set, wr_mask, wr_lock;
   assign wr_ctl   = wr_en_i && hit(addr_i, A_CTL);
   assign wr_cfg   = wr_en_i && unlocked_q && hit(addr_i, A_CFG);
   assign wr_match = wr_en_i && unlocked_q && hit(addr_i, A_MATCH);
   assign wr_lower = wr_en_i && unlocked_q && hit(addr_i, A_LOWER);
   assign wr_cntlo = wr_en_i && unlocked_q && hit(addr_i, A_CNTLO);
   assign wr_cnthi = wr_en_i && unlocked_q && hit(addr_i, A_CNTHI);
   assign wr_stat  = wr_en_i && hit(addr_i, A_STAT);
   assign wr_set   = wr_en_i && hit(addr_i, A_SET);
   assign wr_mask  = wr_en_i && hit(addr_i, A_MASK);
   assign wr_lock  = wr_en_i && hit(addr_i, A_LOCK);

   logic [NCTR-1:0] svc;
   assign svc = wr_ctl ? wdata_i[CTL_SVC_LSB +: NCTR] : '0;

   // ---------------- narrow counters ----------------
   logic [CW-1:0]  lo_cnt [NLO];
   act_e           lo_mode [NLO];
   act_e           lo_lmode [NLO];
   logic [NLO-1:0] lo_clr, lo_evt, lo_carry, lo_adv, lo_viol;

   assign lo_mode[0]  = cfg_q.mode0;
   assign lo_mode[1]  = cfg_q.mode1;
   assign lo_lmode[0] = cfg_q.lmode0;
   assign lo_lmode[1] = cfg_q.lmode1;
   assign lo_clr      = {cfg_q.clr1, cfg_q.clr0};

   for (genvar gi = 0; gi < NLO; gi++) begin : g_lo
      logic step_ok;
      if (gi == 0) begin : g_first
         assign step_ok = 1'b1;
      end else begin : g_chain
         assign step_ok = cfg_q.casc01 ? lo_carry[gi-1] : 1'b1;
      end
      assign lo_adv[gi] = tick_i && en_s2[gi] && step_ok;

      twd_counter #(.CW(CW)) u_ctr (
         .clk_i          (clk_i),
         .rst_ni         (rst_ni),
         .tick_i         (tick_i),
         .adv_i          (lo_adv[gi]),
         .load_i         (wr_cntlo),
         .load_val_i     (wdata_i[gi*CW +: CW]),
         .svc_i          (svc[gi]),
         .match_i        (match_q[gi*CW +: CW]),
         .clr_on_match_i (lo_clr[gi]),
         .cnt_o          (lo_cnt[gi]),
         .evt_o          (lo_evt[gi]),
         .carry_o        (lo_carry[gi])
      );

      assign lo_viol[gi] = svc[gi] && (lo_lmode[gi] != ACT_NONE)
                           && (lo_cnt[gi] < lower_q[gi*CW +: CW]);
   end

   // ---------------- wide toggle counter ----------------
   logic [C2W-1:0] hi_cnt;
   logic           hi_adv, hi_evt;
   assign hi_adv = tick_i && en_s2[NCTR-1] && (cfg_q.casc12 ? lo_carry[NLO-1] : 1'b1);

   twd_toggle #(.W(C2W)) u_wide (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .adv_i      (hi_adv),
      .load_i     (wr_cnthi),
      .load_val_i (wdata_i[C2W-1:0]),
      .svc_i      (svc[NCTR-1]),
      .sel_i      (cfg_q.tog_bit[SW-1:0]),
      .cnt_o      (hi_cnt),
      .evt_o      (hi_evt)
   );

   // ---------------- action resolution ----------------
   act_e            ctr_mode [NCTR];
   logic [NCTR-1:0] ctr_evt;
   assign ctr_mode[0] = cfg_q.mode0;
   assign ctr_mode[1] = cfg_q.mode1;
   assign ctr_mode[2] = cfg_q.mode2;
   assign ctr_evt     = {hi_evt, lo_evt};

   logic [NCTR-1:0] st_set, st_clr;
   logic            any_rst;

   always_comb begin
      act_res_t r;
      st_set  = wr_set ? wdata_i[NCTR-1:0] : '0;
      st_clr  = wr_stat ? wdata_i[NCTR-1:0] : '0;
      any_rst = 1'b0;
      for (int i = 0; i < NCTR; i++) begin
         r = resolve(ctr_mode[i], ctr_evt[i], status_q[i]);
         st_set[i] = st_set[i] | r.set_irq;
         any_rst   = any_rst | r.req_rst;
      end
      for (int i = 0; i < NLO; i++) begin
         r = resolve(lo_lmode[i], lo_viol[i], status_q[i]);
         st_set[i] = st_set[i] | r.set_irq;
         any_rst   = any_rst | r.req_rst;
      end
   end

   // ---------------- register update ----------------
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         unlocked_q <= 1'b0;
         cfg_q      <= '0;
         match_q    <= '0;
         lower_q    <= '0;
         en_q       <= '0;
         en_s1      <= '0;
         en_s2      <= '0;
         status_q   <= '0;
         mask_q     <= '0;
         rst_req_q  <= 1'b0;
      end else begin
         if (wr_lock)  unlocked_q <= (wdata_i == UNLOCK_KEY);
         if (wr_cfg)   cfg_q      <= cfg_t'(wdata_i & CFG_WMASK);
         if (wr_match) match_q    <= wdata_i;
         if (wr_lower) lower_q    <= wdata_i;
         if (wr_ctl)   en_q       <= wdata_i[NCTR-1:0];
         if (wr_mask)  mask_q     <= wdata_i[NCTR-1:0];
         if (tick_i) begin
            en_s1 <= en_q;
            en_s2 <= en_s1;
         end
         status_q  <= (status_q & ~st_clr) | st_set;
         rst_req_q <= rst_req_q | any_rst;
      end
   end

   assign irq_o     = status_q & mask_q;
   assign rst_req_o = rst_req_q;

   always_comb begin
      rdata_o = '0;
      case (addr_i)
         ADDR_W'(A_CTL):   rdata_o = DW'(en_q);
         ADDR_W'(A_CFG):   rdata_o = cfg_q;
         ADDR_W'(A_MATCH): rdata_o = match_q;
         ADDR_W'(A_LOWER): rdata_o = lower_q;
         ADDR_W'(A_CNTLO): rdata_o = {lo_cnt[1], lo_cnt[0]};
         ADDR_W'(A_CNTHI): rdata_o = DW'(hi_cnt);
         ADDR_W'(A_STAT):  rdata_o = DW'(status_q);
         ADDR_W'(A_MASK):  rdata_o = DW'(mask_q);
         ADDR_W'(A_LOCK):  rdata_o = DW'(unlocked_q);
         default:          rdata_o = '0;
      endcase
   end

   // ---------------- assertions ----------------
   // R2: a locked match register ignores writes
   a_r2_locked_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!unlocked_q && wr_en_i && hit(addr_i, A_MATCH)) |=> $stable(match_q));

   // R6: without a pending carry, a cascaded counter 1 holds
   a_r6_c1_waits_carry: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cfg_q.casc01 && !lo_carry[0] && !wr_cntlo && !svc[1]) |=> $stable(lo_cnt[1]));

   // R9: a reset request stays until reset
   a_r9_rst_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rst_req_q |=> rst_req_q);

   // R11: write-one-to-clear removes status bit 0 unless a new set arrives
   a_r11_w1c: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_clr[0] && !st_set[0]) |=> !status_q[0]);

endmodule

// File: tb/tb_tri_wdog.sv
module tb_tri_wdog;

   localparam logic [31:0] KEY = 32'h5EC0_0D1E;
   localparam int NV = 15;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [2:0]  irq;
   logic        rst_req;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   tri_wdog dut (
      .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_en_i(wr_en),
      .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .rst_req_o(rst_req)
   );

   // {req[3:0], wv, wa[3:0], wd[31:0], nt[3:0], ra[3:0], ex[31:0]}
   localparam logic [80:0] VEC [NV] = '{
      {4'd2,  1'b1, 4'd1, 32'h0000_0001, 4'd0, 4'd1, 32'h0000_0000}, // R2 locked cfg
      {4'd2,  1'b1, 4'd9, KEY,            4'd0, 4'd9, 32'h0000_0001}, // R2 unlock
      {4'd2,  1'b1, 4'd2, 32'h0003_0004, 4'd0, 4'd2, 32'h0003_0004}, // R2 match
      {4'd2,  1'b1, 4'd1, 32'h0000_050D, 4'd0, 4'd1, 32'h0000_050D}, // R2 cfg
      {4'd11, 1'b1, 4'd8, 32'h0000_0007, 4'd0, 4'd8, 32'h0000_0007}, // R11 mask
      {4'd3,  1'b1, 4'd0, 32'h0000_0003, 4'd2, 4'd4, 32'h0000_0000}, // R3 two ticks idle
      {4'd3,  1'b0, 4'd0, 32'h0,         4'd1, 4'd4, 32'h0000_0001}, // R3 third tick
      {4'd4,  1'b0, 4'd0, 32'h0,         4'd3, 4'd4, 32'h0000_0004}, // R4 at match
      {4'd4,  1'b0, 4'd0, 32'h0,         4'd1, 4'd6, 32'h0000_0001}, // R4 event
      {4'd4,  1'b0, 4'd0, 32'h0,         4'd0, 4'd4, 32'h0000_0000}, // R4 cleared
      {4'd6,  1'b0, 4'd0, 32'h0,         4'd0, 4'd4, 32'h0000_0000}, // R6 c1 not same tick
      {4'd6,  1'b0, 4'd0, 32'h0,         4'd1, 4'd4, 32'h0001_0001}, // R6 c1 next tick
      {4'd11, 1'b1, 4'd6, 32'h0000_0001, 4'd0, 4'd6, 32'h0000_0000}, // R11 w1c
      {4'd11, 1'b1, 4'd7, 32'h0000_0004, 4'd0, 4'd6, 32'h0000_0004}, // R11 set
      {4'd11, 1'b1, 4'd6, 32'h0000_0004, 4'd0, 4'd6, 32'h0000_0000}  // R11 w1c bit2
   };

   task automatic report;
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic ticks(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk); tick = 1'b1;
         @(negedge clk); tick = 1'b0;
      end
   endtask

   task automatic rd(input string tag, input logic [3:0] a, input logic [31:0] exp);
      @(negedge clk);
      addr = a;
      #1;
      chk(tag, rdata, exp);
   endtask

   task automatic do_reset;
      @(negedge clk); rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic check_reset_state;
      for (int a = 0; a < 10; a++) rd("R1 register zero", 4'(a), 32'h0);
      chk("R1 irq zero", 32'(irq), 32'h0);
      chk("R1 rst_req zero", 32'(rst_req), 32'h0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
   end

   initial begin
      do_reset();
      check_reset_state();                         // R1

      for (int v = 0; v < NV; v++) begin
         logic [80:0] e;
         e = VEC[v];
         if (e[76]) wr(e[75:72], e[71:40]);
         ticks(int'(e[39:36]));
         @(negedge clk);
         addr = e[35:32];
         #1;
         n_chk++;
         if (rdata !== e[31:0]) begin
            n_fail++;
            $display("FAIL R%0d vector %0d: actual %h expected %h", e[80:77], v, rdata, e[31:0]);
         end
      end

      // R5 free running past match, wrap from max
      wr(4'd0, 32'h0); ticks(2);
      wr(4'd1, 32'h0000_0001);
      wr(4'd4, 32'h0000_0003);
      wr(4'd6, 32'h7);
      wr(4'd0, 32'h1);
      ticks(2);
      rd("R3 held before third tick", 4'd4, 32'h3);
      ticks(2);
      rd("R5 passes match", 4'd4, 32'h5);
      rd("R5 event at match", 4'd6, 32'h1);
      wr(4'd4, 32'h0000_FFFF);
      ticks(1);
      rd("R5 wrap from max", 4'd4, 32'h0);

      // R10 window: service below and above the lower limit
      wr(4'd6, 32'h7);
      wr(4'd3, 32'h0000_000A);
      wr(4'd1, 32'h0000_0010);
      wr(4'd0, 32'h11);
      rd("R10 early service flagged", 4'd6, 32'h1);
      wr(4'd6, 32'h1);
      wr(4'd4, 32'h0000_000C);
      wr(4'd0, 32'h11);
      rd("R10 late service not flagged", 4'd6, 32'h0);
      rd("R10 service clears count", 4'd4, 32'h0);

      // R9 mode 3: interrupt first, reset when still pending
      wr(4'd1, 32'h0000_0007);
      wr(4'd6, 32'h7);
      wr(4'd4, 32'h0000_0004);
      ticks(1);
      rd("R9 first event sets status", 4'd6, 32'h1);
      chk("R9 no reset on first event", 32'(rst_req), 32'h0);
      wr(4'd4, 32'h0000_0004);
      ticks(1);
      chk("R9 reset on pending event", 32'(rst_req), 32'h1);
      chk("R11 irq is status and mask", 32'(irq), 32'h1);

      do_reset();
      check_reset_state();                         // R1 after reset request

      // R8 toggle of selected bit
      wr(4'd9, KEY);
      wr(4'd1, 32'h0301_0000);
      wr(4'd5, 32'h6);
      wr(4'd8, 32'h4);
      wr(4'd0, 32'h4);
      ticks(2);
      rd("R3 wide counter held", 4'd5, 32'h6);
      ticks(1);
      rd("R8 no event without toggle", 4'd6, 32'h0);
      ticks(1);
      rd("R8 event on bit toggle", 4'd6, 32'h4);
      chk("R8 irq on toggle", 32'(irq), 32'h4);
      wr(4'd8, 32'h0);
      chk("R11 mask hides irq", 32'(irq), 32'h0);

      // R7 cascade counter 1 into wide counter
      wr(4'd0, 32'h0); ticks(2);
      wr(4'd1, 32'h0000_0800);
      wr(4'd4, 32'hFFFF_0000);
      wr(4'd5, 32'h0);
      wr(4'd0, 32'h6);
      ticks(3);
      rd("R7 c1 wrapped", 4'd4, 32'h0);
      rd("R7 wide waits a tick", 4'd5, 32'h0);
      ticks(1);
      rd("R7 wide advanced", 4'd5, 32'h1);
      rd("R7 c1 counting", 4'd4, 32'h0001_0000);

      // R2 relock
      wr(4'd9, 32'h0);
      rd("R2 relocked", 4'd9, 32'h0);
      wr(4'd2, 32'h0000_1234);
      rd("R2 locked match ignored", 4'd2, 32'h0);

      report();
   end

endmodule